// File: doc/BRIEF.md
# Sequential Offset Register Programmer

This block keeps the two threshold values that a FIFO's almost-empty and almost-full flag logic compares against. Each threshold spans two 8-bit registers, a low byte and a high byte, which gives four registers in all. The registers have no address lines. A write sequence pointer picks the register that the next load goes to. It advances by one on every load and wraps after the last register. A separate read sequence pointer walks the same order when the values are read back onto the FIFO output bus.

Software or a host programs the thresholds through the FIFO's own data path. It holds the load strobe low and uses the normal write enable to push bytes into the registers, one byte per write-clock edge. With the load strobe low, the two read enables pull the bytes back out, one per read-clock edge. With the load strobe high, the same enables turn into plain FIFO write and read strobes, which the block passes on to the storage. The assembled offsets are trimmed to the pointer width that the configured depth needs. A read and a write of the registers in the same cycle is a protocol violation; the block still performs both operations and raises a one-cycle error pulse.

Both clocks may be asynchronous to each other or tied together. Each clock domain has its own reset synchronizer, so reset asserts asynchronously and releases on that domain's clock. The assembled offset is limited to 16 bits, so DEPTH must not exceed 65536.

Top module: `offs_prog`

## Requirements
- R1: After reset the empty offset and the full offset both read 7 (low byte 7, high byte 0). The readback register is 0 and proto_err is 0.
- R2: On a write-clock edge with load_n=0 and wen1_n=0, the low 8 bits of din are stored in the register selected by the write pointer, and the pointer advances. The order is slot 0 empty low byte, slot 1 empty high byte, slot 2 full low byte, slot 3 full high byte.
- R3: After slot 3 the write pointer wraps, so the fifth load lands in the empty low byte again.
- R4: With load_n=0 and wen1_n=1, no register changes and the write pointer does not advance.
- R5: With load_n=1, fifo_wr_en equals the inverse of wen1_n and no offset register changes. With load_n=0, fifo_wr_en is 0.
- R6: The write pointer keeps its position while load_n is high, so a new load session continues with the next slot in order.
- R7: On a read-clock edge with load_n=0, ren1_n=0 and ren2_n=0, rd_data takes the register selected by the read pointer, zero-extended to DATA_W bits, and the read pointer advances in the same slot order and wraps after slot 3.
- R8: If either read enable is high, rd_data and the read pointer hold. With load_n=1 and both read enables low, fifo_rd_en is 1 and rd_data holds.
- R9: The read pointer and the write pointer move independently: reset clears both, and neither one's activity moves the other.
- R10: empty_off is {slot 1, slot 0} and full_off is {slot 3, slot 2}, each trimmed to its low log2(DEPTH) bits. High-byte bits above that width are stored but have no effect on the outputs.
- R11: proto_err is 1 for one write-clock cycle after an edge at which load_n=0, wen1_n=0, ren1_n=0 and ren2_n=0 all held. It is 0 otherwise.
- R12: din bits at position 8 and above never reach an offset register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_n | input | 1 | Load strobe, low selects the offset registers |
| wen1_n | input | 1 | Write enable, active low |
| ren1_n | input | 1 | Read enable 1, active low |
| ren2_n | input | 1 | Read enable 2, active low |
| din | input | DATA_W | FIFO input data bus |
| rd_data | output | DATA_W | Offset readback register driving the output bus |
| fifo_wr_en | output | 1 | Normal FIFO write strobe |
| fifo_rd_en | output | 1 | Normal FIFO read strobe |
| empty_off | output | log2(DEPTH) | Assembled almost-empty offset |
| full_off | output | log2(DEPTH) | Assembled almost-full offset |
| proto_err | output | 1 | Pulse on a simultaneous register read and write |

## Verification
Directed sequences cover these cases:
- A partial load session of two bytes, interrupted by a normal write and an idle load cycle. This separates a pointer that persists from one that restarts, and separates a pointer that is gated from one that is free-running.
- A fifth load. This shows whether the pointer wraps.
- A byte with bit 8 set and high bytes with bits above the offset width set. These show what is trimmed away.
- A readback that starts while the write pointer sits mid-sequence, with a held read in the middle. This shows whether the two pointers are independent and whether reads are gated.
- A combined read and write in one cycle. This checks that the error pulse fires and that both operations still take place.

Random enable and data patterns then mix loads, readbacks, normal traffic and conflicts, and a bench model compares the outputs on every cycle.

// File: rtl/offs_pkg.sv
package offs_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_REGS = 4;
  localparam int PTR_W    = $clog2(NUM_REGS);

  typedef enum logic [PTR_W-1:0] {
    SLOT_EMPTY_LO = 2'd0,
    SLOT_EMPTY_HI = 2'd1,
    SLOT_FULL_LO  = 2'd2,
    SLOT_FULL_HI  = 2'd3
  } slot_e;

  localparam logic [REG_W-1:0] DEF_LO = 8'd7;
  localparam logic [REG_W-1:0] DEF_HI = 8'd0;

  // Even slots hold a low byte, odd slots a high byte.
  function automatic logic [REG_W-1:0] slot_default(input int idx);
    return (idx % 2 == 0) ? DEF_LO : DEF_HI;
  endfunction
endpackage

// File: rtl/offs_rst_sync.sv
module offs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/offs_seq_ptr.sv
module offs_seq_ptr #(
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr
);
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;

  // The pointer wraps naturally at 2**PTR_W.
  always_comb begin
    ptr_d = ptr_q;
    if (adv) ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/offs_reg_bank.sv
module offs_reg_bank
  import offs_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [PTR_W-1:0]                 wsel,
  input  logic [DATA_W-1:0]                wdata,
  output logic [NUM_REGS-1:0][REG_W-1:0]   regs
);
  logic [REG_W-1:0] byte_in;

  // Only the low byte of the bus is stored.
  assign byte_in = wdata[REG_W-1:0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    logic             hit;
    logic [REG_W-1:0] slot_q;
    logic [REG_W-1:0] slot_d;

    assign hit = we && (wsel == PTR_W'(g));

    always_comb begin
      slot_d = slot_q;
      if (hit) slot_d = byte_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= slot_default(g);
      else        slot_q <= slot_d;
    end

    assign regs[g] = slot_q;
  end
endmodule

// File: rtl/offs_readback.sv
module offs_readback
  import offs_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           re,
  input  logic [PTR_W-1:0]               rsel,
  input  logic [NUM_REGS-1:0][REG_W-1:0] regs,
  output logic [DATA_W-1:0]              dout
);
  logic [DATA_W-1:0] dout_q;
  logic [DATA_W-1:0] dout_d;

  always_comb begin
    dout_d = dout_q;
    if (re) dout_d = DATA_W'(regs[rsel]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= '0;
    else        dout_q <= dout_d;
  end

  assign dout = dout_q;
endmodule

// File: rtl/offs_prog.sv
module offs_prog
  import offs_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 1024,
  localparam int OFF_W = $clog2(DEPTH)
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic              wen1_n,
  input  logic              ren1_n,
  input  logic              ren2_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rd_data,
  output logic              fifo_wr_en,
  output logic              fifo_rd_en,
  output logic [OFF_W-1:0]  empty_off,
  output logic [OFF_W-1:0]  full_off,
  output logic              proto_err
);
  logic                           wrst_n;
  logic                           rrst_n;
  logic                           load_req;
  logic                           rdbk_req;
  logic [PTR_W-1:0]               wptr;
  logic [PTR_W-1:0]               rptr;
  logic [NUM_REGS-1:0][REG_W-1:0] regs;
  logic [2*REG_W-1:0]             empty_full;
  logic [2*REG_W-1:0]             full_full;
  logic                           err_q;
  logic                           err_d;

  offs_rst_sync #(.STAGES(2)) u_wrst (
    .clk(wclk), .rst_n_in(rst_n), .rst_n_out(wrst_n)
  );
  offs_rst_sync #(.STAGES(2)) u_rrst (
    .clk(rclk), .rst_n_in(rst_n), .rst_n_out(rrst_n)
  );

  // Decode of the strobes
  assign load_req   = !load_n && !wen1_n;
  assign rdbk_req   = !load_n && !ren1_n && !ren2_n;
  assign fifo_wr_en =  load_n && !wen1_n;
  assign fifo_rd_en =  load_n && !ren1_n && !ren2_n;

  offs_seq_ptr #(.PTR_W(PTR_W)) u_wptr (
    .clk(wclk), .rst_n(wrst_n), .adv(load_req), .ptr(wptr)
  );
  offs_seq_ptr #(.PTR_W(PTR_W)) u_rptr (
    .clk(rclk), .rst_n(rrst_n), .adv(rdbk_req), .ptr(rptr)
  );

  offs_reg_bank #(.DATA_W(DATA_W)) u_bank (
    .clk(wclk), .rst_n(wrst_n), .we(load_req), .wsel(wptr),
    .wdata(din), .regs(regs)
  );

  offs_readback #(.DATA_W(DATA_W)) u_rdbk (
    .clk(rclk), .rst_n(rrst_n), .re(rdbk_req), .rsel(rptr),
    .regs(regs), .dout(rd_data)
  );

  // Assemble and trim to the width the depth needs
  assign empty_full = {regs[SLOT_EMPTY_HI], regs[SLOT_EMPTY_LO]};
  assign full_full  = {regs[SLOT_FULL_HI],  regs[SLOT_FULL_LO]};
  assign empty_off  = empty_full[OFF_W-1:0];
  assign full_off   = full_full[OFF_W-1:0];

  // Protocol error pulse, write domain
  always_comb begin
    err_d = load_req && rdbk_req;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) err_q <= 1'b0;
    else         err_q <= err_d;
  end

  assign proto_err = err_q;
endmodule

// File: rtl/offs_prog_chk.sv
module offs_prog_chk #(
  parameter int DATA_W = 9,
  parameter int OFF_W  = 10
) (
  input logic              wclk,
  input logic              rclk,
  input logic              wrst_n,
  input logic              rrst_n,
  input logic              load_n,
  input logic              wen1_n,
  input logic              ren1_n,
  input logic              ren2_n,
  input logic [DATA_W-1:0] rd_data,
  input logic [OFF_W-1:0]  empty_off,
  input logic [OFF_W-1:0]  full_off,
  input logic              proto_err
);
  // R4: load selected but write enable high leaves offsets untouched
  a_r4_idle_load_hold: assert property (@(posedge wclk) disable iff (!wrst_n)
    (!load_n && wen1_n) |=> ($stable(empty_off) && $stable(full_off)));

  // R5: normal FIFO traffic never touches the offsets
  a_r5_normal_write_hold: assert property (@(posedge wclk) disable iff (!wrst_n)
    load_n |=> ($stable(empty_off) && $stable(full_off)));

  // R8: readback register holds unless both read enables are low
  a_r8_read_gate_hold: assert property (@(posedge rclk) disable iff (!rrst_n)
    (ren1_n || ren2_n) |=> $stable(rd_data));

  // R11: a conflict raises the error flag on the next cycle
  a_r11_err_raise: assert property (@(posedge wclk) disable iff (!wrst_n)
    (!load_n && !wen1_n && !ren1_n && !ren2_n) |=> proto_err);

  // R11: without a conflict the flag is low on the next cycle
  a_r11_err_clear: assert property (@(posedge wclk) disable iff (!wrst_n)
    !(!load_n && !wen1_n && !ren1_n && !ren2_n) |=> !proto_err);
endmodule

bind offs_prog offs_prog_chk #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_chk (
  .wclk(wclk), .rclk(rclk), .wrst_n(wrst_n), .rrst_n(rrst_n),
  .load_n(load_n), .wen1_n(wen1_n), .ren1_n(ren1_n), .ren2_n(ren2_n),
  .rd_data(rd_data), .empty_off(empty_off), .full_off(full_off),
  .proto_err(proto_err)
);

// File: tb/sim_offs_prog.sv
module sim_offs_prog;
  localparam int DATA_W = 9;
  localparam int DEPTH  = 1024;
  localparam int OFF_W  = $clog2(DEPTH);

  logic              clk;
  logic              rst_n;
  logic              load_n, wen1_n, ren1_n, ren2_n;
  logic [DATA_W-1:0] din;
  logic [DATA_W-1:0] rd_data;
  logic              fifo_wr_en, fifo_rd_en, proto_err;
  logic [OFF_W-1:0]  empty_off, full_off;

  int unsigned n_vec;
  int unsigned n_bad;

  logic [7:0]        m_reg [4];
  logic [1:0]        m_wp, m_rp;
  logic [DATA_W-1:0] m_rd;
  logic              m_err;

  offs_prog #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
    .wclk(clk), .rclk(clk), .rst_n(rst_n),
    .load_n(load_n), .wen1_n(wen1_n), .ren1_n(ren1_n), .ren2_n(ren2_n),
    .din(din), .rd_data(rd_data), .fifo_wr_en(fifo_wr_en),
    .fifo_rd_en(fifo_rd_en), .empty_off(empty_off), .full_off(full_off),
    .proto_err(proto_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [OFF_W-1:0] assemble(input logic [7:0] lo, input logic [7:0] hi);
    logic [15:0] w;
    w = {hi, lo};
    return w[OFF_W-1:0];
  endfunction

  task automatic cmp(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive at a falling edge, model the rising edge, compare at the next falling edge
  task automatic apply(input logic ld, input logic we, input logic r1, input logic r2,
                       input logic [DATA_W-1:0] d);
    logic lreq, rreq;
    load_n = ld; wen1_n = we; ren1_n = r1; ren2_n = r2; din = d;
    #1;
    cmp("R5", 16'(fifo_wr_en), 16'(ld && !we));
    cmp("R8", 16'(fifo_rd_en), 16'(ld && !r1 && !r2));
    @(posedge clk);
    lreq = !ld && !we;
    rreq = !ld && !r1 && !r2;
    if (rreq) begin m_rd = DATA_W'(m_reg[m_rp]); m_rp = m_rp + 2'd1; end
    if (lreq) begin m_reg[m_wp] = d[7:0]; m_wp = m_wp + 2'd1; end
    m_err = lreq && rreq;
    @(negedge clk);
    cmp("R2", 16'(empty_off), 16'(assemble(m_reg[0], m_reg[1])));
    cmp("R10", 16'(full_off), 16'(assemble(m_reg[2], m_reg[3])));
    cmp("R7", 16'(rd_data), 16'(m_rd));
    cmp("R11", 16'(proto_err), 16'(m_err));
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    n_vec = 0; n_bad = 0;
    m_reg[0] = 8'd7; m_reg[1] = 8'd0; m_reg[2] = 8'd7; m_reg[3] = 8'd0;
    m_wp = '0; m_rp = '0; m_rd = '0; m_err = 1'b0;
    rst_n = 1'b0; load_n = 1'b1; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1; din = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) apply(1, 1, 1, 1, 9'h000);
    // R1 reset state
    cmp("R1", 16'(empty_off), 16'd7);
    cmp("R1", 16'(full_off), 16'd7);
    cmp("R1", 16'(rd_data), 16'd0);
    cmp("R1", 16'(proto_err), 16'd0);

    // R2 / R6: partial session of two bytes
    apply(0, 0, 1, 1, 9'h034);
    apply(0, 0, 1, 1, 9'h002);
    cmp("R2", 16'(empty_off), 16'h234);
    // R5: normal write leaves offsets alone
    apply(1, 0, 1, 1, 9'h0AA);
    cmp("R5", 16'(empty_off), 16'h234);
    cmp("R5", 16'(full_off), 16'd7);
    // R4: load with write enable high does nothing
    apply(0, 1, 1, 1, 9'h0BB);
    cmp("R4", 16'(full_off), 16'd7);
    // R6 resume at slot 2, R12 bit 8 dropped, R10 trimming
    apply(0, 0, 1, 1, 9'h011);
    cmp("R6", 16'(full_off), 16'h011);
    apply(0, 0, 1, 1, 9'h1FF);
    cmp("R12", 16'(full_off), 16'h311);
    cmp("R10", 16'(empty_off), 16'h234);
    // R3 wrap to slot 0
    apply(0, 0, 1, 1, 9'h055);
    cmp("R3", 16'(empty_off), 16'h255);

    // R9: readback starts at slot 0 although the write pointer is at slot 1
    apply(0, 1, 0, 0, 9'h000);
    cmp("R9", 16'(rd_data), 16'h055);
    apply(0, 1, 1, 0, 9'h000);
    cmp("R8", 16'(rd_data), 16'h055);
    apply(1, 1, 0, 0, 9'h000);
    cmp("R8", 16'(rd_data), 16'h055);
    apply(0, 1, 0, 0, 9'h000);
    cmp("R7", 16'(rd_data), 16'h002);
    apply(0, 1, 0, 0, 9'h000);
    cmp("R7", 16'(rd_data), 16'h011);
    apply(0, 1, 0, 0, 9'h000);
    cmp("R7", 16'(rd_data), 16'h0FF);
    apply(0, 1, 0, 0, 9'h000);
    cmp("R7", 16'(rd_data), 16'h055);

    // R11 conflict: both operations happen, flag pulses
    apply(0, 0, 0, 0, 9'h020);
    cmp("R11", 16'(proto_err), 16'd1);
    cmp("R11", 16'(rd_data), 16'h002);
    cmp("R10", 16'(empty_off), 16'h055);
    apply(1, 1, 1, 1, 9'h000);
    cmp("R11", 16'(proto_err), 16'd0);

    // Random traffic against the model
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      logic ld, we, r1, r2;
      ld = ($urandom % 3) != 0 ? 1'b0 : 1'b1;
      we = $urandom % 2;
      r1 = ($urandom % 3) == 0;
      r2 = ($urandom % 3) == 0;
      apply(ld, we, r1, r2, DATA_W'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule